// File: doc/BRIEF.md
# SPI flash write-protection controller

This block sits at the serial edge of a NOR flash and turns SPI command frames into guarded program and erase requests. It runs as an SPI slave on clock, active-low select, data in and data out. The serial pins are oversampled by the system clock. Data in is taken on rising serial-clock edges and data out changes on falling edges, so the block works in both mode 0 and mode 3. It decodes write-enable, write-disable, status read, status write, page program, sector erase, block erase and chip erase.

A status register holds a write-enable latch, a three-bit protection code and a lock bit. The protection code guards a region of the array that is aligned to the top. The array has eight 64 KB blocks, and block 7 is the highest. The block number is taken from address bits [18:16] of the 24-bit address. A command runs only when select rises on a byte boundary. A program or erase that is allowed goes to the backend as a one-cycle strobe, together with a job kind and an address. The backend reports its busy state back into the status byte.

Top module: `nor_wp_front`

## Requirements
- R1: SPI modes 0 and 3 both work. Data in is sampled on rising serial-clock edges while select is low. Data out changes only on falling edges, and the most significant bit comes first.
- R2: Opcode 06h sets the write-enable latch.
- R3: Opcode 04h clears the write-enable latch.
- R4: Opcode 05h streams the status byte for as long as select stays low. The layout is: bit0 = backend busy, bit1 = write-enable latch, bits[4:2] = protection code, bit7 = lock, and bits 6:5 = 0. Each byte is captured when its first bit is driven.
- R5: Opcode 01h followed by a data byte loads the protection code from data bits [4:2] and the lock from data bit 7, then clears the latch. This happens only when the latch is 1 and the lock is 0.
- R6: While the lock is 1, opcode 01h is ignored. The protection code, the lock and the latch all stay unchanged.
- R7: The protection code selects the locked blocks: 000 = none, 001 = block 7, 010 = blocks 6-7, 011 = blocks 4-7, 100 to 111 = all blocks.
- R8: Page program (02h) needs the opcode, 3 address bytes and at least 1 data byte. Sector erase (20h) and block erase (D8h) need the opcode and 3 address bytes. When one of these runs, the block pulses op_vld_o for one cycle with op_kind_o (0 program, 1 sector, 2 block) and the 24-bit address, and clears the latch.
- R9: Chip erase (C7h) is issued as kind 3 with address 0 only when the protection code is 000. Otherwise it is ignored.
- R10: Program, erase and status-write commands are ignored when the latch is 0. Program and erase are also ignored when the target block is locked. An ignored command produces no strobe and leaves the latch unchanged.
- R11: A frame is discarded if select rises off a byte boundary or before all the required bytes have arrived. A discarded frame changes neither the latch nor the strobe.
- R12: After reset, the latch, the protection code and the lock are 0, data out is low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock |
| cs_ni | input | 1 | SPI select, active low |
| si_i | input | 1 | SPI data in |
| so_o | output | 1 | SPI data out |
| busy_i | input | 1 | Backend busy, reported as status bit 0 |
| op_vld_o | output | 1 | One-cycle strobe for a permitted program or erase |
| op_kind_o | output | 2 | Job kind: 0 program, 1 sector, 2 block, 3 chip |
| op_addr_o | output | 24 | Target address of the job |

## Verification
Two events can fall in the same cycle window: the backend busy input can change just as a status byte is latched for shifting. The bench flips busy at the same falling edge that starts a repeated status byte, and again in the middle of a byte. Every byte must show the busy value present at its own first falling edge. A flip in the middle of a byte must not reach that byte and must appear in the next one.

// File: rtl/nor_wp_pkg.sv
package nor_wp_pkg;

  localparam logic [7:0] OP_SET_WE = 8'h06;
  localparam logic [7:0] OP_CLR_WE = 8'h04;
  localparam logic [7:0] OP_RD_ST  = 8'h05;
  localparam logic [7:0] OP_WR_ST  = 8'h01;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SECT   = 8'h20;
  localparam logic [7:0] OP_BLK    = 8'hD8;
  localparam logic [7:0] OP_CHIP   = 8'hC7;

  typedef enum logic [1:0] {
    JOB_PROG = 2'd0,
    JOB_SECT = 2'd1,
    JOB_BLK  = 2'd2,
    JOB_CHIP = 2'd3
  } job_e;

endpackage

// File: rtl/nor_wp_spi_if.sv
module nor_wp_spi_if #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic             si_i,
  input  logic             tx_en_i,
  input  logic [7:0]       tx_byte_i,
  output logic             so_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] byte_idx_o,
  output logic             end_o,
  output logic             end_ok_o,
  output logic [CNT_W-1:0] nbytes_o
);

  localparam int SW = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  // {sclk, cs_n, si}
  logic [SW-1:0][2:0] sync_q;
  logic sclk_d, cs_d;
  logic sclk_s, cs_s, si_s;
  logic rise, fall, sel_go, sel_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {SW{3'b010}};
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      for (int k = SW - 1; k > 0; k--) sync_q[k] <= sync_q[k-1];
      sync_q[0] <= {sclk_i, cs_ni, si_i};
      sclk_d    <= sclk_s;
      cs_d      <= cs_s;
    end
  end

  assign sclk_s  = sync_q[SW-1][2];
  assign cs_s    = sync_q[SW-1][1];
  assign si_s    = sync_q[SW-1][0];
  assign rise    = sclk_s & ~sclk_d & ~cs_s;
  assign fall    = ~sclk_s & sclk_d & ~cs_s;
  assign sel_go  = ~cs_s & cs_d;
  assign sel_end = cs_s & ~cs_d;

  // receive side
  logic [2:0]       bit_q;
  logic [6:0]       sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bvld_q, end_q, ok_q;
  logic [7:0]       byte_q;
  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      bvld_q <= 1'b0;
      byte_q <= '0;
      idx_q  <= '0;
      end_q  <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      bvld_q <= rise && (bit_q == 3'd7);
      end_q  <= sel_end;
      if (sel_end) ok_q <= (bit_q == 3'd0);
      if (sel_go) begin
        bit_q <= '0;
        cnt_q <= '0;
      end else if (rise) begin
        sh_q  <= {sh_q[5:0], si_s};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          byte_q <= {sh_q, si_s};
          idx_q  <= cnt_q;
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_vld_o = bvld_q;
  assign byte_o     = byte_q;
  assign byte_idx_o = idx_q;
  assign end_o      = end_q;
  assign end_ok_o   = ok_q;
  assign nbytes_o   = cnt_q;

  // transmit side
  logic [2:0] tbit_q;
  logic [6:0] tsh_q;
  logic       so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbit_q <= '0;
      tsh_q  <= '0;
      so_q   <= 1'b0;
    end else if (sel_go) begin
      tbit_q <= '0;
    end else if (fall) begin
      if (tx_en_i) begin
        if (tbit_q == 3'd0) {so_q, tsh_q} <= tx_byte_i;
        else                {so_q, tsh_q} <= {tsh_q, 1'b0};
        tbit_q <= tbit_q + 3'd1;
      end else begin
        so_q <= 1'b0;
      end
    end
  end

  assign so_o = so_q;

  // R1
  so_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(so_q));

  // R11
  byte_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvld_q |=> !bvld_q);

endmodule

// File: rtl/nor_wp_prot.sv
module nor_wp_prot #(
  parameter int BLK_W = 3
) (
  input  logic [2:0]       code_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             hit_o,
  output logic             any_o
);

  localparam int NBLK = 1 << BLK_W;

  logic [BLK_W:0] floor_b;

  // top-aligned region: partial codes lock the upper 2^(code-1) blocks
  always_comb begin
    floor_b = '0;
    hit_o   = 1'b0;
    if (code_i == 3'd0) begin
      hit_o = 1'b0;
    end else if (32'(code_i) > BLK_W) begin
      hit_o = 1'b1;
    end else begin
      floor_b = (BLK_W+1)'(NBLK) - ((BLK_W+1)'(1) << (code_i - 3'd1));
      hit_o   = {1'b0, blk_i} >= floor_b;
    end
  end

  assign any_o = (code_i != 3'd0);

  // R7
  always_comb begin
    top_blk_chk: assert (!(any_o && blk_i == '1) || hit_o);
    none_chk: assert (any_o || !hit_o);
  end

endmodule

// File: rtl/nor_wp_cmd.sv
module nor_wp_cmd
  import nor_wp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [CNT_W-1:0]  byte_idx_i,
  input  logic              end_i,
  input  logic              end_ok_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  input  logic              busy_i,
  input  logic              blk_hit_i,
  input  logic              any_prot_i,
  output logic              tx_en_o,
  output logic [7:0]        status_o,
  output logic [2:0]        code_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              op_vld_o,
  output logic [1:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam logic [CNT_W-1:0] N_ERASE = CNT_W'(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] N_PROG  = CNT_W'(ADDR_BYTES + 2);
  localparam logic [CNT_W-1:0] N_WRST  = CNT_W'(2);
  localparam logic [CNT_W-1:0] N_ONE   = CNT_W'(1);

  logic [7:0]        opc_q, wdat_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, wel_q, srwd_q;
  logic [2:0]        bp_q;

  logic              nxt_wel, nxt_srwd, issue;
  logic [2:0]        nxt_bp;
  job_e              kind;

  always_comb begin
    nxt_wel  = wel_q;
    nxt_bp   = bp_q;
    nxt_srwd = srwd_q;
    issue    = 1'b0;
    kind     = JOB_PROG;
    if (end_i && end_ok_i && nbytes_i >= N_ONE) begin
      case (opc_q)
        OP_SET_WE: nxt_wel = 1'b1;
        OP_CLR_WE: nxt_wel = 1'b0;
        OP_WR_ST: if (nbytes_i >= N_WRST && wel_q && !srwd_q) begin
          nxt_bp   = wdat_q[4:2];
          nxt_srwd = wdat_q[7];
          nxt_wel  = 1'b0;
        end
        OP_PROG: if (nbytes_i >= N_PROG && wel_q && !blk_hit_i) begin
          issue   = 1'b1;
          kind    = JOB_PROG;
          nxt_wel = 1'b0;
        end
        OP_SECT, OP_BLK: if (nbytes_i >= N_ERASE && wel_q && !blk_hit_i) begin
          issue   = 1'b1;
          kind    = (opc_q == OP_SECT) ? JOB_SECT : JOB_BLK;
          nxt_wel = 1'b0;
        end
        OP_CHIP: if (wel_q && !any_prot_i) begin
          issue   = 1'b1;
          kind    = JOB_CHIP;
          nxt_wel = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q     <= '0;
      wdat_q    <= '0;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      wel_q     <= 1'b0;
      bp_q      <= '0;
      srwd_q    <= 1'b0;
      op_vld_o  <= 1'b0;
      op_kind_o <= '0;
      op_addr_o <= '0;
    end else begin
      if (byte_vld_i) begin
        if (byte_idx_i == '0) begin
          opc_q <= byte_i;
          rd_q  <= (byte_i == OP_RD_ST);
        end else if (byte_idx_i <= CNT_W'(ADDR_BYTES)) begin
          addr_q <= {addr_q[ADDR_W-9:0], byte_i};
        end
        if (byte_idx_i == N_ONE) wdat_q <= byte_i;
      end
      if (end_i) rd_q <= 1'b0;
      wel_q     <= nxt_wel;
      bp_q      <= nxt_bp;
      srwd_q    <= nxt_srwd;
      op_vld_o  <= issue;
      op_kind_o <= kind;
      op_addr_o <= (kind == JOB_CHIP) ? '0 : addr_q;
    end
  end

  assign tx_en_o  = rd_q;
  assign status_o = {srwd_q, 2'b00, bp_q, wel_q, busy_i};
  assign code_o   = bp_q;
  assign addr_o   = addr_q;

  // R10
  wel_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_vld_o |-> $past(wel_q));

  // R8
  wel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_vld_o |-> !wel_q);

  // R7
  no_locked_job_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_vld_o && op_kind_o != JOB_CHIP) |-> !blk_hit_i);

  // R9
  chip_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_vld_o && op_kind_o == JOB_CHIP) |-> (!any_prot_i && op_addr_o == '0));

  // R6
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srwd_q |=> (srwd_q && $stable(bp_q)));

  // R11
  wel_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wel_q) |-> $past(end_i && end_ok_i));

endmodule

// File: rtl/nor_wp_front.sv
module nor_wp_front #(
  parameter int ADDR_W      = 24,
  parameter int BLK_LSB     = 16,
  parameter int BLK_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              si_i,
  output logic              so_o,
  input  logic              busy_i,
  output logic              op_vld_o,
  output logic [1:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 3);

  logic             byte_vld, end_ev, end_ok, tx_en, blk_hit, any_prot;
  logic [7:0]       rx_byte, status;
  logic [CNT_W-1:0] byte_idx, nbytes;
  logic [2:0]       code;
  logic [ADDR_W-1:0] addr;

  nor_wp_spi_if #(
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W)
  ) u_spi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .cs_ni     (cs_ni),
    .si_i      (si_i),
    .tx_en_i   (tx_en),
    .tx_byte_i (status),
    .so_o      (so_o),
    .byte_vld_o(byte_vld),
    .byte_o    (rx_byte),
    .byte_idx_o(byte_idx),
    .end_o     (end_ev),
    .end_ok_o  (end_ok),
    .nbytes_o  (nbytes)
  );

  nor_wp_cmd #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_vld_i(byte_vld),
    .byte_i    (rx_byte),
    .byte_idx_i(byte_idx),
    .end_i     (end_ev),
    .end_ok_i  (end_ok),
    .nbytes_i  (nbytes),
    .busy_i    (busy_i),
    .blk_hit_i (blk_hit),
    .any_prot_i(any_prot),
    .tx_en_o   (tx_en),
    .status_o  (status),
    .code_o    (code),
    .addr_o    (addr),
    .op_vld_o  (op_vld_o),
    .op_kind_o (op_kind_o),
    .op_addr_o (op_addr_o)
  );

  nor_wp_prot #(
    .BLK_W(BLK_W)
  ) u_prot (
    .code_i(code),
    .blk_i (addr[BLK_LSB +: BLK_W]),
    .hit_o (blk_hit),
    .any_o (any_prot)
  );

endmodule

// File: tb/nor_wp_front_bench.sv
module nor_wp_front_bench;

  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0, busy = 1'b0;
  logic so, op_vld;
  logic [1:0] op_kind;
  logic [23:0] op_addr;

  always #2 clk = ~clk;

  nor_wp_front u_nor_wp_front (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .busy_i(busy), .op_vld_o(op_vld), .op_kind_o(op_kind),
    .op_addr_o(op_addr)
  );

  int n_cmp = 0, n_bad = 0;
  logic [25:0] opq[$];
  logic [7:0]  stq[$];
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  logic [25:0] mon_e;
  bit m_wel = 0, m_srwd = 0;
  logic [2:0] m_bp = 3'd0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every strobe is matched against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && op_vld) begin
      if (opq.size() == 0) chk(1'b0, "R10 unexpected strobe", {6'd0, op_kind, op_addr}, 0);
      else begin
        mon_e = opq.pop_front();
        chk({op_kind, op_addr} == mon_e, "R8 strobe kind/addr",
            {6'd0, op_kind, op_addr}, {6'd0, mon_e});
      end
    end
  end

  function automatic bit m_prot(input logic [2:0] c, input logic [2:0] b);
    if (c == 3'd0) return 1'b0;
    if (c > 3'd3) return 1'b1;
    return int'(b) >= (8 - (1 << (int'(c) - 1)));
  endfunction

  function automatic logic [7:0] m_stat(input bit bz);
    return {m_srwd, 2'b00, m_bp, m_wel, bz};
  endfunction

  task automatic xfer(input int nbits, input bit m3, input int flip_at);
    logic [7:0] acc = '0;
    rxq.delete();
    sclk = m3;
    repeat (HP) @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i == flip_at) busy = ~busy;
      sclk = 1'b0;
      si = (i / 8 < txq.size()) ? txq[i/8][7-(i%8)] : 1'b0;
      repeat (HP) @(negedge clk);
      acc = {acc[6:0], so};
      if (i % 8 == 7) rxq.push_back(acc);
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
    end
    if (!m3) sclk = 1'b0;
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HP) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    chk(opq.size() == 0, tag, opq.size(), 0);
  endtask

  task automatic wren(input bit m3);
    txq = '{8'h06}; xfer(8, m3, -1); m_wel = 1;
  endtask

  task automatic wrdi(input bit m3);
    txq = '{8'h04}; xfer(8, m3, -1); m_wel = 0;
  endtask

  task automatic wrsr(input logic [7:0] d, input bit m3);
    txq = '{8'h01, d}; xfer(16, m3, -1);
    if (m_wel && !m_srwd) begin
      m_bp = d[4:2]; m_srwd = d[7]; m_wel = 0;
    end
  endtask

  task automatic addr_cmd(input logic [7:0] op, input logic [23:0] a, input int extra,
                          input bit m3, input string tag);
    int need = (op == 8'h02) ? 5 : 4;
    txq = '{op, a[23:16], a[15:8], a[7:0]};
    for (int k = 0; k < extra; k++) txq.push_back(8'hA5 + 8'(k));
    if (m_wel && !m_prot(m_bp, a[18:16]) && (4 + extra) >= need) begin
      opq.push_back({(op == 8'h02) ? 2'd0 : (op == 8'h20) ? 2'd1 : 2'd2, a});
      m_wel = 0;
    end
    xfer(8 * (4 + extra), m3, -1);
    drained(tag);
  endtask

  task automatic chip(input bit m3, input string tag);
    if (m_wel && m_bp == 3'd0) begin
      opq.push_back({2'd3, 24'd0}); m_wel = 0;
    end
    txq = '{8'hC7}; xfer(8, m3, -1);
    drained(tag);
  endtask

  task automatic rd_status(input int nb, input int flip_at, input bit m3, input string tag);
    bit b0 = busy;
    for (int j = 1; j <= nb; j++)
      stq.push_back(m_stat(b0 ^ (flip_at >= 0 && 8 * j >= flip_at)));
    txq = '{8'h05};
    xfer(8 * (nb + 1), m3, flip_at);
    for (int j = 1; j <= nb; j++) begin
      logic [7:0] e = stq.pop_front();
      chk(rxq[j] == e, tag, rxq[j], e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(so == 1'b0, "R12 so low in reset", so, 0);
    chk(op_vld == 1'b0, "R12 no strobe in reset", op_vld, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_status(1, -1, 0, "R12 status after reset");

    // R2 and R4: latch set, status repeats
    wren(0);
    rd_status(3, -1, 0, "R2 R4 latch set, repeated status");
    wrdi(1);
    rd_status(1, -1, 1, "R3 latch cleared (mode 3, R1)");

    // R10: modify with latch clear
    addr_cmd(8'h02, 24'h070010, 1, 0, "R10 program without latch");
    wrsr(8'h1C, 0);
    rd_status(1, -1, 0, "R10 status write without latch");

    // R8: program, sector, block
    wren(0);
    addr_cmd(8'h02, 24'h070010, 2, 0, "R8 program issued");
    rd_status(1, -1, 0, "R8 latch cleared after program");
    wren(1);
    addr_cmd(8'h20, 24'h012345, 0, 1, "R8 sector erase mode 3 R1");
    wren(0);
    addr_cmd(8'hD8, 24'h050000, 0, 0, "R8 block erase");

    // R5 status write
    wren(1);
    wrsr(8'h64, 1);
    rd_status(1, -1, 1, "R5 code 001 loaded, bits 6:5 read 0");

    // R7 and R10: locked block leaves latch set
    wren(0);
    addr_cmd(8'h20, 24'h07FFFF, 0, 0, "R7 block 7 locked");
    rd_status(1, -1, 0, "R10 latch kept after reject");
    addr_cmd(8'hD8, 24'h060000, 0, 0, "R7 block 6 free at code 001");

    // R9 chip erase refused while a block is locked
    wren(0);
    chip(0, "R9 chip erase refused");

    // R7 sweep of every code over every block
    for (int c = 0; c < 8; c++) begin
      wren(0);
      wrsr(8'(c << 2), 0);
      rd_status(1, -1, 0, "R5 code sweep load");
      for (int b = 0; b < 8; b++) begin
        wren(0);
        addr_cmd(8'h20, 24'(b << 16) | 24'h000123, 0, 0, "R7 sweep");
      end
    end
    wren(0);
    wrsr(8'h00, 0);
    wren(0);
    chip(1, "R9 chip erase issued at code 000");

    // R11: short or misaligned frames
    wren(0);
    addr_cmd(8'h02, 24'h001000, 0, 0, "R11 program missing data byte");
    txq = '{8'h20, 8'h00, 8'h10, 8'h00, 8'h00};
    xfer(35, 0, -1);
    drained("R11 misaligned erase");
    rd_status(1, -1, 0, "R11 latch kept after short frames");
    wrdi(0);
    txq = '{8'h06}; xfer(5, 0, -1);
    rd_status(1, -1, 0, "R11 partial enable ignored");

    // R4 busy captured per byte, flip at byte start and in mid byte
    rd_status(3, 16, 0, "R4 busy flip at byte start");
    rd_status(3, 20, 1, "R4 busy flip mid byte");
    busy = 1'b0;

    // R6 lock
    wren(0);
    wrsr(8'h88, 0);
    wren(0);
    wrsr(8'h00, 0);
    rd_status(1, -1, 0, "R6 locked status write ignored");
    addr_cmd(8'hD8, 24'h070000, 0, 0, "R6 locked code still guards");

    repeat (20) @(negedge clk);
    drained("R8 queue empty at end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule